// File: doc/BRIEF.md
# Shared Interrupt Target Register Bank

This block holds the per-interrupt CPU routing choice of an interrupt distributor serving up to eight CPUs. Software reaches it through single-cycle 32-bit register accesses addressed by word index; each word carries one byte per interrupt, four interrupts to a word. The first eight words belong to the per-CPU private interrupts. They cannot be written, and a read returns the requesting CPU's own one-bit mask in every byte.

Words from index 8 upward describe the shared interrupts, with interrupt number equal to word index times four plus byte lane, minus 32. Every shared interrupt stores exactly one target CPU index. A write narrows each byte to the lowest set bit that names an implemented CPU, and an empty byte picks CPU0. From the stored indices the block drives one routing bitmap per CPU. The bitmap bit of an interrupt is set for its chosen CPU only. Any write that lands on a shared word raises a one-cycle update pulse, which downstream delivery logic uses to re-evaluate its state.

Top module: `irq_target_regs`

## Requirements
- R1: After reset every shared interrupt targets CPU0: shared words read 0x01010101 and only CPU0's routing bitmap has bits set.
- R2: A write to shared word w stores, for byte lane k (bits 8k+7..8k), the index of the lowest set bit among the implemented CPU bits (bit positions 0..NUM_CPUS-1) as the target of shared interrupt 4*(w-8)+k.
- R3: A byte with no set bit among the implemented CPU positions selects CPU0. Bits for CPUs at or above NUM_CPUS have no effect.
- R4: A read of a shared word returns, in each byte lane, a one-hot mask with bit t set, where t is the stored target of that lane's interrupt.
- R5: A read of words 0..7 returns (1 << cpu_id_i) replicated into all four bytes. A write there changes no target and raises no update.
- R6: route_o bit c*NUM_SPI+s is 1 exactly when shared interrupt s targets CPU c, so every shared interrupt has exactly one routing bit set.
- R7: update_o is high for the single cycle after the clock edge that takes a write to an implemented shared word, and is low at all other times.
- R8: Words at index 8+NUM_SPI/4 and above read as zero, and writes to them change no target and raise no update.
- R9: A read request is answered at the next clock edge: rvalid_o is high for one cycle and rdata_o carries the data. rdata_o holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| cpu_id_i | input | CPU_W | Index of the CPU performing the access |
| word_addr_i | input | WA_W | Word index (byte offset / 4) |
| wdata_i | input | 32 | Write data, one byte per interrupt |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle |
| update_o | output | 1 | Pulse after a write to a shared target word |
| route_o | output | NUM_CPUS*NUM_SPI | Per-CPU routing bitmaps, CPU c at bits c*NUM_SPI upward |

## Verification
The bench builds the block with NUM_CPUS=4 and NUM_IRQS=48. That gives sixteen shared interrupts in words 8 to 11, and word 12 is the first unimplemented index. With only four CPUs, random bytes often set bits 4 to 7 alone, which exercises the rule that bits for missing CPUs are discarded before the lowest-bit choice (R3). A random mix of private, shared and out-of-range accesses from all four CPU indices is compared against a bench model of the target table. Directed writes of 0x00, 0xF0 and 0xFF bytes cover the default and masking corners.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  localparam int PRIV_WORDS = 8;  // 32 private interrupts, 4 per word
  localparam int LANES      = 4;
  localparam int LANE_W     = 8;
  localparam int MAX_CPUS   = 8;

  function automatic logic [LANE_W-1:0] cpu_mask(input int ncpu);
    logic [LANE_W-1:0] m;
    for (int i = 0; i < LANE_W; i++) m[i] = (i < ncpu);
    return m;
  endfunction
endpackage

// File: rtl/irqt_lane_pick.sv
module irqt_lane_pick
  import irqt_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int CPU_W    = 3
) (
  input  logic [LANE_W-1:0] byte_i,
  output logic [CPU_W-1:0]  idx_o
);
  localparam logic [LANE_W-1:0] IMPL = cpu_mask(NUM_CPUS);

  logic [LANE_W-1:0] masked;
  assign masked = byte_i & IMPL;

  // lowest implemented set bit wins, empty -> CPU0
  always_comb begin
    idx_o = '0;
    for (int i = LANE_W - 1; i >= 0; i--)
      if (masked[i]) idx_o = CPU_W'(i);
  end

  // R2/R3: chosen bit is set and nothing below it is
  always_comb begin
    if (masked != '0) begin
      a_r2_lowest_bit: assert (masked[idx_o] && ((masked & ((LANE_W'(1) << idx_o) - LANE_W'(1))) == '0));
    end else begin
      a_r3_empty_cpu0: assert (idx_o == '0);
    end
  end
endmodule

// File: rtl/irqt_target_store.sv
module irqt_target_store
  import irqt_pkg::*;
#(
  parameter int NUM_SPI = 32,
  parameter int CPU_W   = 3,
  parameter int WA_W    = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [WA_W-1:0]                   word_i,
  input  logic [LANES-1:0][CPU_W-1:0]       idx_i,
  output logic [NUM_SPI-1:0][CPU_W-1:0]     tgt_o
);
  for (genvar s = 0; s < NUM_SPI; s++) begin : g_spi
    localparam logic [WA_W-1:0] MY_WORD = WA_W'(PRIV_WORDS + s / LANES);
    localparam int MY_LANE = s % LANES;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          tgt_o[s] <= '0;
      else if (wr_i && word_i == MY_WORD)   tgt_o[s] <= idx_i[MY_LANE];
    end
  end
endmodule

// File: rtl/irqt_route_decode.sv
module irqt_route_decode #(
  parameter int NUM_CPUS = 8,
  parameter int NUM_SPI  = 32,
  parameter int CPU_W    = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SPI-1:0][CPU_W-1:0] tgt_i,
  output logic [NUM_CPUS*NUM_SPI-1:0]   route_o
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SPI; s++) begin : g_spi
      assign route_o[c*NUM_SPI + s] = (tgt_i[s] == CPU_W'(c));
    end
  end

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_chk
    logic [NUM_CPUS-1:0] col;
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_col
      assign col[c] = route_o[c*NUM_SPI + s];
    end
    // R6: exactly one CPU owns each shared interrupt
    a_r6_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(col) == 1);
  end
endmodule

// File: rtl/irq_target_regs.sv
module irq_target_regs
  import irqt_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_IRQS = 64,
  parameter int WA_W     = 8,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int NUM_SPI = NUM_IRQS - 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [CPU_W-1:0]            cpu_id_i,
  input  logic [WA_W-1:0]             word_addr_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  output logic                        rvalid_o,
  output logic                        update_o,
  output logic [NUM_CPUS*NUM_SPI-1:0] route_o
);
  localparam int NUM_WORDS = NUM_SPI / LANES;
  localparam logic [WA_W-1:0] SHR_LO = WA_W'(PRIV_WORDS);
  localparam logic [WA_W-1:0] SHR_HI = WA_W'(PRIV_WORDS + NUM_WORDS);

  logic priv_hit, shr_hit, shr_wr;
  assign priv_hit = word_addr_i < SHR_LO;
  assign shr_hit  = (word_addr_i >= SHR_LO) && (word_addr_i < SHR_HI);
  assign shr_wr   = req_i && we_i && shr_hit;

  logic [LANES-1:0][CPU_W-1:0] lane_idx;
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    irqt_lane_pick #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) i_pick (
      .byte_i (wdata_i[k*LANE_W +: LANE_W]),
      .idx_o  (lane_idx[k])
    );
  end

  logic [NUM_SPI-1:0][CPU_W-1:0] tgt;
  irqt_target_store #(.NUM_SPI(NUM_SPI), .CPU_W(CPU_W), .WA_W(WA_W)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (shr_wr),
    .word_i (word_addr_i),
    .idx_i  (lane_idx),
    .tgt_o  (tgt)
  );

  irqt_route_decode #(.NUM_CPUS(NUM_CPUS), .NUM_SPI(NUM_SPI), .CPU_W(CPU_W)) i_route (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tgt_i   (tgt),
    .route_o (route_o)
  );

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (priv_hit) begin
      rd_word = {LANES{LANE_W'(1) << cpu_id_i}};
    end else begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (word_addr_i == WA_W'(PRIV_WORDS + w))
          for (int k = 0; k < LANES; k++)
            rd_word[k*LANE_W +: LANE_W] = LANE_W'(1) << tgt[w*LANES + k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      update_o <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      update_o <= shr_wr;
      if (req_i && !we_i) rdata_o <= rd_word;
    end
  end

  // R9: read answered on the next edge
  a_r9_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  // R9: data holds between reads
  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  // R7: no update without a write on the previous edge
  a_r7_update_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> !update_o);
  // R5/R8: writes outside the shared range leave routing unchanged
  a_r5_r8_no_route_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !shr_hit) |=> $stable(route_o));
  // R7: no update for a write outside the shared range
  a_r7_update_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !shr_hit) |=> !update_o);
endmodule

// File: tb/test_irq_target_regs.sv
module test_irq_target_regs;
  localparam int NC   = 4;
  localparam int NI   = 48;
  localparam int NS   = NI - 32;
  localparam int CW   = 2;
  localparam int AW   = 8;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [CW-1:0] cpu = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, upd;
  logic [NC*NS-1:0] route;

  int errors = 0, checks = 0;
  int exp_tgt [NS];

  always #4 clk = ~clk;

  irq_target_regs #(.NUM_CPUS(NC), .NUM_IRQS(NI), .WA_W(AW)) i_irq_target_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .cpu_id_i(cpu),
    .word_addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .update_o(upd), .route_o(route)
  );

  function automatic int pick(input logic [7:0] b);
    for (int i = 0; i < NC; i++) if (b[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(input int a, input int c);
    logic [31:0] v = '0;
    if (a < 8) v = {4{8'(1) << c}};
    else if (a < 8 + NS/4)
      for (int k = 0; k < 4; k++) v[k*8 +: 8] = 8'(1) << exp_tgt[(a-8)*4 + k];
    return v;
  endfunction

  function automatic logic [NC*NS-1:0] exp_route();
    logic [NC*NS-1:0] r = '0;
    for (int s = 0; s < NS; s++) r[exp_tgt[s]*NS + s] = 1'b1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req_tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic do_write(input int c, input int a, input logic [31:0] d);
    bit in_shr;
    @(negedge clk);
    req = 1; we = 1; cpu = CW'(c); addr = AW'(a); wdata = d;
    in_shr = (a >= 8) && (a < 8 + NS/4);
    if (in_shr)
      for (int k = 0; k < 4; k++) exp_tgt[(a-8)*4 + k] = pick(d[k*8 +: 8]);
    @(negedge clk);
    req = 0; we = 0;
    chk(upd == in_shr, in_shr ? "R7 update after shared write" : "R5/R8 no update", 128'(upd), 128'(in_shr));
    chk(route == exp_route(), in_shr ? "R2/R6 route" : "R5/R8 route unchanged", 128'(route), 128'(exp_route()));
    @(negedge clk);
    chk(upd == 1'b0, "R7 single-cycle pulse", 128'(upd), 128'(0));
  endtask

  task automatic do_read(input int c, input int a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    req = 1; we = 0; cpu = CW'(c); addr = AW'(a);
    e = exp_read(a, c);
    @(negedge clk);
    req = 0;
    chk(rvalid == 1'b1, "R9 rvalid", 128'(rvalid), 128'(1));
    chk(rdata == e, tag, 128'(rdata), 128'(e));
    @(negedge clk);
    chk(rvalid == 1'b0 && rdata == e, "R9 hold", 128'({rvalid, rdata}), 128'({1'b0, e}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < NS; s++) exp_tgt[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(route == exp_route(), "R1 reset route", 128'(route), 128'(exp_route()));
    chk(upd == 0 && rvalid == 0, "R1 reset outputs", 128'({upd, rvalid}), 128'(0));
    for (int a = 8; a < 8 + NS/4; a++) do_read(0, a, "R1 reset read 0x01010101");
    // R5 private reads per CPU and ignored writes
    for (int c = 0; c < NC; c++) do_read(c, c, "R5 private mask");
    do_write(2, 3, 32'hFFFF_FFFF);
    do_read(2, 3, "R5 private after write");
    // R2 / R3 directed
    do_write(1, 8, 32'h0C_06_F0_00);   // lanes: 0->0, F0->0 (R3), 06->1, 0C->2
    do_read(1, 8, "R2/R3/R4 directed lanes");
    do_write(0, 9, 32'h08_FF_04_30);   // 30->0 (R3 masked), 04->2, FF->0, 08->3
    do_read(3, 9, "R2/R4 lowest bit");
    // R8 out-of-range
    do_write(0, 8 + NS/4, 32'h0808_0808);
    do_read(0, 8 + NS/4, "R8 out of range zero");
    do_read(1, 200, "R8 far out of range");
    // random mix
    for (int i = 0; i < 300; i++) begin
      int a, c;
      c = $urandom_range(NC-1);
      case ($urandom_range(9))
        0, 1:    a = $urandom_range(7);
        2:       a = $urandom_range(255, 8 + NS/4);
        default: a = $urandom_range(8 + NS/4 - 1, 8);
      endcase
      if ($urandom_range(1)) do_write(c, a, $urandom);
      else do_read(c, a, "R4 random read");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule